// File: doc/BRIEF.md
# Flagless Widening Multiply Execution Unit

This unit executes an unsigned widening multiply. One multiplicand is always the implicit D general register; the other is an explicit register or memory operand, already fetched. The double-width product is cut into a high half and a low half, and each half leaves on its own register-file write port with its own destination index. The high half goes to the register named by the instruction's ModRM reg field. The low half goes to the register named by the vvvv field. The unit never requests a flags update, so software can interleave it freely with add-with-carry chains.

The decoder hands over the W and L bits, the processor mode, both destination indices and the two source values with a valid/ready handshake. The unit checks for illegal use in the cycle it accepts a request. It then either faults at once or runs a radix-4 shift-add multiply, two multiplier bits per cycle. It ends every request with a single-cycle `done` pulse, which also carries either the write requests or the undefined-opcode flag.

Top module: `wide_mul_unit`

## Requirements
- R1: Operand size is 32 bits when `procMode` is not 2'b11, or when `wBit` is 0. The unit then multiplies `dReg[31:0]` by `srcOp[31:0]` and ignores the upper 32 bits of both. Product bits 31:0 leave on `loWrData` and bits 63:32 on `hiWrData`, each zero-extended to 64 bits.
- R2: With `procMode` = 2'b11 (64-bit mode) and `wBit` = 1, the full 64-bit `dReg` is multiplied by `srcOp`. Product bits 63:0 leave on `loWrData` and bits 127:64 on `hiWrData`.
- R3: On a completed multiply, `hiWrIdx` equals the accepted `hiIdx` (ModRM reg field) and `loWrIdx` equals the accepted `loIdx` (vvvv field). Write enables are high only while `done` is high.
- R4: When the two accepted indices are equal, only the high-half write is issued (`hiWrEn`=1, `loWrEn`=0), so that register receives the high half.
- R5: `flagWrEn` is 0 at all times.
- R6: A request accepted with `lBit`=1 ends on the next cycle with `done`=1 and `udFault`=1, and with both write enables low.
- R7: A request accepted with `procMode` 2'b00 (real mode) or 2'b01 (virtual-8086 mode) faults exactly as in R6, whatever the values of `wBit` and `lBit`. Mode 2'b10 is 32-bit protected mode.
- R8: `done` rises 17 cycles after the accepting edge for a 32-bit multiply, 33 cycles after it for a 64-bit multiply, and 1 cycle after it for a faulting request. It stays high for exactly one cycle.
- R9: `startReady` is high only while the unit is idle. A `startValid` raised while `startReady` is low is ignored and does not change the result in flight.
- R10: After reset, `startReady`=1, and `done`, `udFault`, `hiWrEn` and `loWrEn` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Request valid |
| startReady | output | 1 | Unit idle, request can be accepted |
| wBit | input | 1 | Decoded W bit |
| lBit | input | 1 | Decoded L bit |
| procMode | input | 2 | 00 real, 01 virtual-8086, 10 protected 32-bit, 11 64-bit |
| hiIdx | input | 4 | High-half destination (ModRM reg) |
| loIdx | input | 4 | Low-half destination (vvvv) |
| dReg | input | 64 | Value of the implicit D register |
| srcOp | input | 64 | Explicit source operand |
| hiWrEn | output | 1 | High-half write enable |
| hiWrIdx | output | 4 | High-half write index |
| hiWrData | output | 64 | High-half write data |
| loWrEn | output | 1 | Low-half write enable |
| loWrIdx | output | 4 | Low-half write index |
| loWrData | output | 64 | Low-half write data |
| flagWrEn | output | 1 | Flags update enable, held at 0 |
| udFault | output | 1 | Undefined-opcode exception, valid with done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The multiply runs with all-ones operands, where every partial product carries, and with a zero operand. It also runs with a single top bit times two, which lands exactly on the half boundary, and with mixed constants. Together these separate a correct accumulation from dropped carries or a misplaced split. In the 32-bit cases the upper source bits are deliberately filled with garbage, which exposes any leak into the narrow product or a missing zero-extension. The W-ignored cases (mode 10 with W=1, mode 11 with W=0) tell the size selection apart from a plain W decode, and the equal-index cases tell high-half priority apart from last-writer order.

// File: rtl/wide_mul_pkg.sv
package wide_mul_pkg;
  // Multiplier bits retired per iteration
  localparam int RADIX_BITS = 2;

  typedef enum logic [1:0] {
    MODE_REAL = 2'b00,
    MODE_V86  = 2'b01,
    MODE_PROT = 2'b10,
    MODE_LONG = 2'b11
  } procMode_e;

  // Control to datapath strobes
  typedef struct packed {
    logic load;   // capture operands, clear accumulator
    logic wide;   // operand size is full width (valid with load)
    logic step;   // retire RADIX_BITS multiplier bits
  } mulStrobe_t;
endpackage

// File: rtl/wide_mul_ctrl.sv
module wide_mul_ctrl
  import wide_mul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       wBit,
  input  logic       lBit,
  input  logic [1:0] procMode,
  output logic       startReady,
  output logic       done,
  output logic       fault,
  output mulStrobe_t strobe
);
  localparam int STEPS_WIDE   = XLEN / RADIX_BITS;
  localparam int STEPS_NARROW = STEPS_WIDE / 2;
  localparam int CNT_W        = $clog2(STEPS_WIDE);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;

  state_e             state;
  logic [CNT_W-1:0]   stepCnt;
  logic               faultQ;
  logic               accept;
  logic               reqFault;
  logic               reqWide;

  assign accept   = startValid && (state == ST_IDLE);
  assign reqFault = lBit || (procMode == MODE_REAL) || (procMode == MODE_V86);
  assign reqWide  = (procMode == MODE_LONG) && wBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      faultQ  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          faultQ <= reqFault;
          if (reqFault) begin
            state <= ST_DONE;
          end else begin
            state   <= ST_RUN;
            stepCnt <= reqWide ? CNT_W'(STEPS_WIDE - 1) : CNT_W'(STEPS_NARROW - 1);
          end
        end
        ST_RUN: begin
          if (stepCnt == '0) state <= ST_DONE;
          else               stepCnt <= stepCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign startReady  = (state == ST_IDLE);
  assign done        = (state == ST_DONE);
  assign fault       = done && faultQ;
  assign strobe.load = accept && !reqFault;
  assign strobe.wide = reqWide;
  assign strobe.step = (state == ST_RUN);
endmodule

// File: rtl/wide_mul_dp.sv
module wide_mul_dp
  import wide_mul_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  mulStrobe_t       strobe,
  input  logic [XLEN-1:0]  dReg,
  input  logic [XLEN-1:0]  srcOp,
  input  logic [IDX_W-1:0] hiIdx,
  input  logic [IDX_W-1:0] loIdx,
  output logic [XLEN-1:0]  hiData,
  output logic [XLEN-1:0]  loData,
  output logic [IDX_W-1:0] hiIdxQ,
  output logic [IDX_W-1:0] loIdxQ
);
  localparam int PROD_W = 2 * XLEN;
  localparam int HALF   = XLEN / 2;

  logic [PROD_W-1:0] mcand;
  logic [XLEN-1:0]   mplier;
  logic [PROD_W-1:0] acc;
  logic [PROD_W-1:0] partial;
  logic              wideQ;

  always_comb begin
    partial = '0;
    for (int k = 0; k < RADIX_BITS; k++) begin
      if (mplier[k]) partial = partial + (mcand << k);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
      wideQ  <= 1'b0;
      hiIdxQ <= '0;
      loIdxQ <= '0;
    end else if (strobe.load) begin
      wideQ  <= strobe.wide;
      hiIdxQ <= hiIdx;
      loIdxQ <= loIdx;
      acc    <= '0;
      if (strobe.wide) begin
        mcand  <= {{XLEN{1'b0}}, dReg};
        mplier <= srcOp;
      end else begin
        mcand  <= {{(PROD_W-HALF){1'b0}}, dReg[HALF-1:0]};
        mplier <= {{HALF{1'b0}}, srcOp[HALF-1:0]};
      end
    end else if (strobe.step) begin
      acc    <= acc + partial;
      mcand  <= mcand << RADIX_BITS;
      mplier <= mplier >> RADIX_BITS;
    end
  end

  assign hiData = wideQ ? acc[PROD_W-1:XLEN] : {{HALF{1'b0}}, acc[XLEN-1:HALF]};
  assign loData = wideQ ? acc[XLEN-1:0]      : {{HALF{1'b0}}, acc[HALF-1:0]};
endmodule

// File: rtl/wide_mul_unit.sv
module wide_mul_unit
  import wide_mul_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  output logic             startReady,
  input  logic             wBit,
  input  logic             lBit,
  input  logic [1:0]       procMode,
  input  logic [IDX_W-1:0] hiIdx,
  input  logic [IDX_W-1:0] loIdx,
  input  logic [XLEN-1:0]  dReg,
  input  logic [XLEN-1:0]  srcOp,
  output logic             hiWrEn,
  output logic [IDX_W-1:0] hiWrIdx,
  output logic [XLEN-1:0]  hiWrData,
  output logic             loWrEn,
  output logic [IDX_W-1:0] loWrIdx,
  output logic [XLEN-1:0]  loWrData,
  output logic             flagWrEn,
  output logic             udFault,
  output logic             done
);
  mulStrobe_t strobe;

  wide_mul_ctrl #(.XLEN(XLEN)) i_ctrl (
    .clk, .rstN, .startValid, .wBit, .lBit, .procMode,
    .startReady, .done, .fault(udFault), .strobe
  );

  wide_mul_dp #(.XLEN(XLEN), .IDX_W(IDX_W)) i_dp (
    .clk, .rstN, .strobe, .dReg, .srcOp, .hiIdx, .loIdx,
    .hiData(hiWrData), .loData(loWrData), .hiIdxQ(hiWrIdx), .loIdxQ(loWrIdx)
  );

  // High half wins a shared destination by suppressing the low write
  assign hiWrEn   = done && !udFault;
  assign loWrEn   = hiWrEn && (loWrIdx != hiWrIdx);
  assign flagWrEn = 1'b0;
endmodule

// File: rtl/wide_mul_checker.sv
module wide_mul_checker #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             startValid,
  input logic             startReady,
  input logic             lBit,
  input logic [1:0]       procMode,
  input logic             done,
  input logic             udFault,
  input logic             hiWrEn,
  input logic             loWrEn,
  input logic [IDX_W-1:0] hiWrIdx,
  input logic [IDX_W-1:0] loWrIdx
);
  logic accept;
  assign accept = startValid && startReady;

  p_writes_in_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hiWrEn || loWrEn) |-> done);

  p_hi_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hiWrEn && (hiWrIdx == loWrIdx)) |-> !loWrEn);

  p_fault_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    udFault |-> (done && !hiWrEn && !loWrEn));

  p_l_fault_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accept && lBit) |=> (done && udFault));

  p_mode_fault_r7: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !procMode[1]) |=> (done && udFault));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !startReady);

  p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> startReady);
endmodule

bind wide_mul_unit wide_mul_checker #(.IDX_W(IDX_W)) i_chk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .startReady(startReady),
  .lBit(lBit), .procMode(procMode), .done(done), .udFault(udFault),
  .hiWrEn(hiWrEn), .loWrEn(loWrEn), .hiWrIdx(hiWrIdx), .loWrIdx(loWrIdx)
);

// File: tb/test_wide_mul_unit.sv
`timescale 1ns/1ps
module test_wide_mul_unit;
  localparam int XLEN  = 64;
  localparam int IDX_W = 4;
  localparam int LAT_NARROW = XLEN / 4 + 1;
  localparam int LAT_WIDE   = XLEN / 2 + 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startValid = 1'b0;
  logic             startReady;
  logic             wBit = 1'b0;
  logic             lBit = 1'b0;
  logic [1:0]       procMode = 2'b10;
  logic [IDX_W-1:0] hiIdx = '0;
  logic [IDX_W-1:0] loIdx = '0;
  logic [XLEN-1:0]  dReg = '0;
  logic [XLEN-1:0]  srcOp = '0;
  logic             hiWrEn, loWrEn, flagWrEn, udFault, done;
  logic [IDX_W-1:0] hiWrIdx, loWrIdx;
  logic [XLEN-1:0]  hiWrData, loWrData;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wide_mul_unit #(.XLEN(XLEN), .IDX_W(IDX_W)) i_wide_mul_unit (
    .clk, .rstN, .startValid, .startReady, .wBit, .lBit, .procMode,
    .hiIdx, .loIdx, .dReg, .srcOp, .hiWrEn, .hiWrIdx, .hiWrData,
    .loWrEn, .loWrIdx, .loWrData, .flagWrEn, .udFault, .done
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one request, wait for done, check every output against the requirements
  task automatic runOp(input logic w, input logic l, input logic [1:0] m,
                       input logic [IDX_W-1:0] hi, input logic [IDX_W-1:0] lo,
                       input logic [XLEN-1:0] d, input logic [XLEN-1:0] s);
    bit wide, flt;
    int lat, expLat;
    logic [127:0] prod;
    logic [XLEN-1:0] expHi, expLo;
    wide = (m == 2'b11) && w;
    flt  = l || (m[1] == 1'b0);
    if (wide) prod = {64'b0, d} * {64'b0, s};
    else      prod = {96'b0, d[31:0]} * {96'b0, s[31:0]};
    expHi  = wide ? prod[127:64] : {32'b0, prod[63:32]};
    expLo  = wide ? prod[63:0]   : {32'b0, prod[31:0]};
    expLat = flt ? 1 : (wide ? LAT_WIDE : LAT_NARROW);
    @(negedge clk);
    check(startReady == 1'b1, "R9 ready before request", 128'(startReady), 128'd1);
    startValid = 1'b1; wBit = w; lBit = l; procMode = m;
    hiIdx = hi; loIdx = lo; dReg = d; srcOp = s;
    @(posedge clk);
    #1 startValid = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      check(flagWrEn == 1'b0, "R5 flags untouched", 128'(flagWrEn), 128'd0);
    end while (!done && lat < 100);
    check(lat == expLat, "R8 latency", 128'(lat), 128'(expLat));
    check(udFault == flt, flt ? "R6/R7 fault raised" : "R7 no fault", 128'(udFault), 128'(flt));
    if (flt) begin
      check(!hiWrEn && !loWrEn, "R6 no writes on fault", {hiWrEn, loWrEn}, 128'd0);
    end else begin
      check(hiWrEn == 1'b1, "R3 high write enable", 128'(hiWrEn), 128'd1);
      check(hiWrIdx == hi, "R3 high index", 128'(hiWrIdx), 128'(hi));
      check(hiWrData == expHi, wide ? "R2 high half" : "R1 high half", 128'(hiWrData), 128'(expHi));
      if (hi == lo) begin
        check(loWrEn == 1'b0, "R4 collision low suppressed", 128'(loWrEn), 128'd0);
      end else begin
        check(loWrEn == 1'b1, "R3 low write enable", 128'(loWrEn), 128'd1);
        check(loWrIdx == lo, "R3 low index", 128'(loWrIdx), 128'(lo));
        check(loWrData == expLo, wide ? "R2 low half" : "R1 low half", 128'(loWrData), 128'(expLo));
      end
    end
    @(negedge clk);
    check(!done && !hiWrEn && !loWrEn, "R8 done single pulse", {done, hiWrEn, loWrEn}, 128'd0);
  endtask

  task automatic t_reset();
    check(startReady == 1'b1, "R10 ready", 128'(startReady), 128'd1);
    check(!done && !udFault, "R10 done and fault low", {done, udFault}, 128'd0);
    check(!hiWrEn && !loWrEn, "R10 enables low", {hiWrEn, loWrEn}, 128'd0);
    check(flagWrEn == 1'b0, "R5 flags at reset", 128'(flagWrEn), 128'd0);
  endtask

  task automatic t_mul32();
    runOp(1'b0, 1'b0, 2'b10, 4'd3, 4'd9, 64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_5678_FFFF_FFFF); // R1 all ones
    runOp(1'b0, 1'b0, 2'b10, 4'd1, 4'd2, 64'hFFFF_FFFF_8000_0000, 64'hAAAA_AAAA_0000_0002); // R1 boundary
    runOp(1'b0, 1'b0, 2'b11, 4'd7, 4'd0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210); // R1 W=0 in 64-bit mode
    runOp(1'b1, 1'b0, 2'b10, 4'd4, 4'd5, 64'hFFFF_0000_1357_9BDF, 64'h0F0F_F0F0_2468_ACE0); // R1 W ignored
    runOp(1'b0, 1'b0, 2'b10, 4'd6, 4'd8, 64'h5555_5555_0000_0000, 64'h1111_1111_ABCD_EF01); // R1 zero operand
  endtask

  task automatic t_mul64();
    runOp(1'b1, 1'b0, 2'b11, 4'd10, 4'd11, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF); // R2 all ones
    runOp(1'b1, 1'b0, 2'b11, 4'd12, 4'd13, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0002); // R2 boundary
    runOp(1'b1, 1'b0, 2'b11, 4'd14, 4'd15, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210); // R2 mixed
    runOp(1'b1, 1'b0, 2'b11, 4'd2, 4'd3, 64'h0, 64'hDEAD_BEEF_CAFE_F00D);                     // R2 zero
  endtask

  task automatic t_collide();
    runOp(1'b1, 1'b0, 2'b11, 4'd5, 4'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0003); // R4 wide
    runOp(1'b0, 1'b0, 2'b10, 4'd9, 4'd9, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0010); // R4 narrow
  endtask

  task automatic t_lFault();
    runOp(1'b1, 1'b1, 2'b11, 4'd1, 4'd2, 64'h7, 64'h9); // R6 in 64-bit mode
    runOp(1'b0, 1'b1, 2'b10, 4'd3, 4'd4, 64'h7, 64'h9); // R6 in protected mode
  endtask

  task automatic t_modeFault();
    runOp(1'b0, 1'b0, 2'b00, 4'd1, 4'd2, 64'h5, 64'h6); // R7 real mode
    runOp(1'b1, 1'b0, 2'b00, 4'd1, 4'd2, 64'h5, 64'h6); // R7 real mode W=1
    runOp(1'b0, 1'b0, 2'b01, 4'd1, 4'd2, 64'h5, 64'h6); // R7 virtual-8086
    runOp(1'b1, 1'b0, 2'b01, 4'd1, 4'd2, 64'h5, 64'h6); // R7 virtual-8086 W=1
  endtask

  // R9: a second request while busy is held off and leaves the first result intact
  task automatic t_busy();
    logic [127:0] prod;
    int lat;
    prod = {64'b0, 64'h0000_0001_0000_0003} * {64'b0, 64'h0000_0002_0000_0005};
    @(negedge clk);
    startValid = 1'b1; wBit = 1'b1; lBit = 1'b0; procMode = 2'b11;
    hiIdx = 4'd8; loIdx = 4'd9; dReg = 64'h0000_0001_0000_0003; srcOp = 64'h0000_0002_0000_0005;
    @(posedge clk);
    #1 startValid = 1'b0;
    repeat (3) @(negedge clk);
    startValid = 1'b1; wBit = 1'b0; procMode = 2'b10; hiIdx = 4'd1; loIdx = 4'd1;
    dReg = 64'hFFFF; srcOp = 64'hFFFF;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(startReady == 1'b0, "R9 ready low while busy", 128'(startReady), 128'd0);
    end
    startValid = 1'b0;
    lat = 8;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check(lat == LAT_WIDE, "R9 in-flight latency kept", 128'(lat), 128'(LAT_WIDE));
    check(hiWrIdx == 4'd8 && loWrIdx == 4'd9, "R9 indices kept", {hiWrIdx, loWrIdx}, {4'd8, 4'd9});
    check(hiWrData == prod[127:64], "R9 high result kept", 128'(hiWrData), prod[127:64]);
    check(loWrData == prod[63:0], "R9 low result kept", 128'(loWrData), prod[63:0]);
    @(negedge clk);
    check(startReady == 1'b1 && !done, "R9 idle after done", {startReady, done}, 128'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mul32();
    t_mul64();
    t_collide();
    t_lFault();
    t_modeFault();
    t_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule